// File: doc/BRIEF.md
# Four-Channel Nibble I/O Port

This block holds four 4-bit output registers, one for each of channels R0 to R3. Each register drives its own group of four common pins. The pins serve both as inputs and as outputs. A 2-bit operand taken from the instruction picks the channel. An output operation stores a nibble in the chosen register. The nibble comes from one of two sources: the accumulator or the B register. A pattern operation takes one 8-bit word fetched from program ROM and loads two registers in the same cycle: the upper nibble goes to R3 and the lower nibble to R2.

An input operation reads the chosen channel. The register keeps driving its pins while the read takes place, so the pin behaves as a quasi-bidirectional line. The value read is therefore the register AND-ed with the external pin level. A latch bit of 0 pulls its pin low, and a 1 lets the outside world set the level. Software that needs the bare pin level writes 15 to the channel first. Reset sets every register to all ones, so the pins come up as inputs.

The pins are sampled in the second cycle of an input instruction. The sampled value is registered once and then presented on the read port. The read port also carries a flag that says whether the result goes to A or to B. The pad circuitry and the ROM are outside this block.

Top module: `nibble_port`

## Requirements
- R1: While reset is asserted and after reset, every channel register holds 4'hF (pin_drive all ones) and rd_valid is 0.
- R2: When out_en is 1, the register of channel chan loads acc_in if sel_b is 0 or breg_in if sel_b is 1. The change is visible one cycle later. The other channels keep their values.
- R3: When pat_en is 1, R3 loads pat_word[7:4] and R2 loads pat_word[3:0] in the same cycle. R0 and R1 are unchanged.
- R4: If out_en and pat_en are both 1 and chan is 2 or 3, the output operation wins on that channel. The pattern still loads the other of R2 and R3.
- R5: An input request (in_en) accepted at clock edge E is sampled at edge E+1. rd_valid is 1 for exactly the cycle after edge E+1. rd_data reflects pin_in as it stood just before edge E+1.
- R6: rd_to_b equals the sel_b value given with the input request (0 means the accumulator, 1 means B).
- R7: rd_data is the bitwise AND of the selected register and the selected pin group. A register of 4'hF returns the pin level unchanged, and a register bit of 0 reads as 0 whatever the pin level.
- R8: Channel n drives pin_drive[4n+3:4n], and pin_in[4n+3:4n] is the pin group read for channel n.
- R9: Input requests on consecutive cycles give results on consecutive cycles, in order, each with its own channel and destination.
- R10: If an output operation writes the channel being sampled at edge E+1, the read uses the register value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| out_en | input | 1 | Output operation strobe |
| pat_en | input | 1 | Pattern operation strobe |
| in_en | input | 1 | Input operation strobe |
| chan | input | 2 | Channel operand, 0 to 3 |
| sel_b | input | 1 | 0 selects the accumulator, 1 selects B (source or destination) |
| acc_in | input | 4 | Accumulator value |
| breg_in | input | 4 | B register value |
| pat_word | input | 8 | ROM word for the pattern load |
| pin_in | input | 16 | External pin levels, channel n at bits 4n+3:4n |
| pin_drive | output | 16 | Register outputs driving the pins |
| rd_valid | output | 1 | Input result valid |
| rd_to_b | output | 1 | Destination of the input result, 1 means B |
| rd_data | output | 4 | Input result nibble |

## Verification
The hardest case is the read sample window. The bench has to show that the pin value comes from the second cycle of the instruction and not from the issue cycle. It also has to show that the register value used is the one from before a write that happens in that same cycle. Both need inputs that change exactly one cycle after the request. So the scenario tasks change pin_in, and in one case issue an output operation to the same channel, on the falling edge that follows the request. The tasks then check that the result follows the later pins and the older register value. A second case drives two requests on back-to-back cycles to prove that the pending stage and the result stage work as a pipeline.

// File: rtl/nibble_port_pkg.sv
package nibble_port_pkg;
    parameter int NIB_W = 4;
    parameter int CH_N  = 4;
    localparam int CH_AW = $clog2(CH_N);
    localparam int BUS_W = NIB_W * CH_N;

    typedef logic [CH_AW-1:0] chan_t;
    typedef logic [NIB_W-1:0] nib_t;

    typedef struct packed {
        logic  pend;
        chan_t pend_chan;
        logic  pend_to_b;
        logic  vld;
        logic  to_b;
        nib_t  data;
    } rd_state_t;
endpackage

// File: rtl/np_chan_reg.sv
module np_chan_reg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic [W-1:0] wr_val,
    input  logic         pat_hit,
    input  logic [W-1:0] pat_val,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_hit) begin
            st_d.val = wr_val;
        end else if (pat_hit) begin
            st_d.val = pat_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.val <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign q = st_q.val;

    // R2
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> q == $past(wr_val));
    // R4
    pat_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pat_hit && !wr_hit) |=> q == $past(pat_val));
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !pat_hit) |=> $stable(q));
endmodule

// File: rtl/np_read_path.sv
module np_read_path
    import nibble_port_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_en,
    input  chan_t            req_chan,
    input  logic             req_to_b,
    input  logic [BUS_W-1:0] latch_all,
    input  logic [BUS_W-1:0] pin_all,
    output logic             rd_valid,
    output logic             rd_to_b,
    output nib_t             rd_data
);
    rd_state_t st_d, st_q;
    nib_t      sel_latch;
    nib_t      sel_pin;

    assign sel_latch = latch_all[st_q.pend_chan*NIB_W +: NIB_W];
    assign sel_pin   = pin_all[st_q.pend_chan*NIB_W +: NIB_W];

    always_comb begin
        st_d           = st_q;
        st_d.pend      = req_en;
        st_d.pend_chan = req_en ? req_chan : st_q.pend_chan;
        st_d.pend_to_b = req_en ? req_to_b : st_q.pend_to_b;
        st_d.vld       = st_q.pend;
        if (st_q.pend) begin
            st_d.to_b = st_q.pend_to_b;
            st_d.data = sel_latch & sel_pin;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{pend: 1'b0, pend_chan: '0, pend_to_b: 1'b0,
                      vld: 1'b0, to_b: 1'b0, data: '1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid = st_q.vld;
    assign rd_to_b  = st_q.to_b;
    assign rd_data  = st_q.data;

    // R5
    rd_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_en |=> ##1 rd_valid);
    // R5
    rd_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.pend |=> !rd_valid);
    // R7
    wired_and_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pend |=> (rd_data & ~$past(sel_latch)) == '0);
    // R6
    dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_en |=> ##1 (rd_to_b == $past(req_to_b, 2)));
endmodule

// File: rtl/nibble_port.sv
module nibble_port
    import nibble_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 out_en,
    input  logic                 pat_en,
    input  logic                 in_en,
    input  logic [CH_AW-1:0]     chan,
    input  logic                 sel_b,
    input  logic [NIB_W-1:0]     acc_in,
    input  logic [NIB_W-1:0]     breg_in,
    input  logic [2*NIB_W-1:0]   pat_word,
    input  logic [BUS_W-1:0]     pin_in,
    output logic [BUS_W-1:0]     pin_drive,
    output logic                 rd_valid,
    output logic                 rd_to_b,
    output logic [NIB_W-1:0]     rd_data
);
    localparam int PAT_LO_CH = CH_N - 2;
    localparam int PAT_HI_CH = CH_N - 1;

    nib_t src_val;
    assign src_val = sel_b ? breg_in : acc_in;

    for (genvar ch = 0; ch < CH_N; ch++) begin : g_chan
        logic wr_hit;
        logic pat_hit;
        nib_t pat_val;

        assign wr_hit = out_en && (chan == CH_AW'(ch));

        if (ch == PAT_HI_CH) begin : g_hi
            assign pat_hit = pat_en;
            assign pat_val = pat_word[2*NIB_W-1:NIB_W];
        end else if (ch == PAT_LO_CH) begin : g_lo
            assign pat_hit = pat_en;
            assign pat_val = pat_word[NIB_W-1:0];
        end else begin : g_none
            assign pat_hit = 1'b0;
            assign pat_val = '1;
        end

        np_chan_reg #(.W(NIB_W)) reg_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_hit (wr_hit),
            .wr_val (src_val),
            .pat_hit(pat_hit),
            .pat_val(pat_val),
            .q      (pin_drive[ch*NIB_W +: NIB_W])
        );
    end

    np_read_path rd_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_en   (in_en),
        .req_chan (chan),
        .req_to_b (sel_b),
        .latch_all(pin_drive),
        .pin_all  (pin_in),
        .rd_valid (rd_valid),
        .rd_to_b  (rd_to_b),
        .rd_data  (rd_data)
    );
endmodule

// File: tb/nibble_port_tb.sv
module nibble_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        out_en = 1'b0, pat_en = 1'b0, in_en = 1'b0;
    logic [1:0]  chan = '0;
    logic        sel_b = 1'b0;
    logic [3:0]  acc_in = '0, breg_in = '0;
    logic [7:0]  pat_word = '0;
    logic [15:0] pin_in = '1;
    logic [15:0] pin_drive;
    logic        rd_valid, rd_to_b;
    logic [3:0]  rd_data;

    int checks = 0;
    int errors = 0;
    logic [3:0] model [4];

    always #10 clk = ~clk;

    nibble_port dut_i (
        .clk(clk), .rst_n(rst_n), .out_en(out_en), .pat_en(pat_en),
        .in_en(in_en), .chan(chan), .sel_b(sel_b), .acc_in(acc_in),
        .breg_in(breg_in), .pat_word(pat_word), .pin_in(pin_in),
        .pin_drive(pin_drive), .rd_valid(rd_valid), .rd_to_b(rd_to_b),
        .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model_bus();
        return {model[3], model[2], model[1], model[0]};
    endfunction

    task automatic write_ch(input logic [1:0] c, input logic b, input logic [3:0] a_v, input logic [3:0] b_v);
        @(negedge clk);
        out_en = 1'b1; chan = c; sel_b = b; acc_in = a_v; breg_in = b_v;
        @(negedge clk);
        out_en = 1'b0;
        model[c] = b ? b_v : a_v;
    endtask

    task automatic test_reset();
        @(negedge clk);
        check("R1 drive in reset", pin_drive, 16'hFFFF);
        check("R1 valid in reset", {15'd0, rd_valid}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 drive after reset", pin_drive, 16'hFFFF);
        check("R1 valid after reset", {15'd0, rd_valid}, 16'd0);
    endtask

    task automatic test_write();
        write_ch(2'd1, 1'b0, 4'h3, 4'hC);
        check("R2 acc source ch1", pin_drive, model_bus());
        write_ch(2'd0, 1'b1, 4'h7, 4'h5);
        check("R2 b source ch0", pin_drive, model_bus());
        check("R8 ch0 lane", {12'd0, pin_drive[3:0]}, 16'h0005);
        check("R8 ch1 lane", {12'd0, pin_drive[7:4]}, 16'h0003);
    endtask

    task automatic test_pattern();
        @(negedge clk);
        pat_en = 1'b1; pat_word = 8'hA6;
        @(negedge clk);
        pat_en = 1'b0;
        model[3] = 4'hA; model[2] = 4'h6;
        check("R3 pattern load", pin_drive, model_bus());
    endtask

    task automatic test_conflict();
        @(negedge clk);
        pat_en = 1'b1; pat_word = 8'h21;
        out_en = 1'b1; chan = 2'd3; sel_b = 1'b0; acc_in = 4'h9;
        @(negedge clk);
        pat_en = 1'b0; out_en = 1'b0;
        model[3] = 4'h9; model[2] = 4'h1;
        check("R4 output wins on R3", pin_drive, model_bus());
    endtask

    task automatic do_read(input string tag, input logic [1:0] c, input logic b,
                           input logic [15:0] early_pins, input logic [15:0] late_pins,
                           input logic [3:0] exp);
        @(negedge clk);
        in_en = 1'b1; chan = c; sel_b = b; pin_in = early_pins;
        @(negedge clk);
        in_en = 1'b0; pin_in = late_pins;
        check({tag, " R5 no early valid"}, {15'd0, rd_valid}, 16'd0);
        @(negedge clk);
        check({tag, " R5 valid"}, {15'd0, rd_valid}, 16'd1);
        check({tag, " R7 data"}, {12'd0, rd_data}, {12'd0, exp});
        check({tag, " R6 dest"}, {15'd0, rd_to_b}, {15'd0, b});
        @(negedge clk);
        check({tag, " R5 single pulse"}, {15'd0, rd_valid}, 16'd0);
    endtask

    task automatic test_reads();
        write_ch(2'd2, 1'b0, 4'hF, 4'h0);
        do_read("ch2 clean", 2'd2, 1'b0, 16'h0000, 16'hF5FF, 4'h5);
        do_read("ch1 masked", 2'd1, 1'b1, 16'hFFFF, 16'hFFFF, 4'h3);
        do_read("ch0 and", 2'd0, 1'b1, 16'h0000, 16'hFFF6, 4'h4);
    endtask

    task automatic test_back_to_back();
        pin_in = 16'h9FFF;
        @(negedge clk);
        in_en = 1'b1; chan = 2'd3; sel_b = 1'b1;
        @(negedge clk);
        chan = 2'd1; sel_b = 1'b0;
        @(negedge clk);
        in_en = 1'b0;
        check("R9 first data", {12'd0, rd_data}, {12'd0, model[3] & 4'h9});
        check("R9 first dest", {15'd0, rd_to_b}, 16'd1);
        @(negedge clk);
        check("R9 second valid", {15'd0, rd_valid}, 16'd1);
        check("R9 second data", {12'd0, rd_data}, {12'd0, model[1]});
        check("R9 second dest", {15'd0, rd_to_b}, 16'd0);
    endtask

    task automatic test_same_cycle_write();
        pin_in = 16'hFFFF;
        write_ch(2'd0, 1'b0, 4'hE, 4'h0);
        @(negedge clk);
        in_en = 1'b1; chan = 2'd0; sel_b = 1'b0;
        @(negedge clk);
        in_en = 1'b0; out_en = 1'b1; acc_in = 4'h1;
        @(negedge clk);
        out_en = 1'b0;
        model[0] = 4'h1;
        check("R10 old latch used", {12'd0, rd_data}, 16'h000E);
        check("R10 write landed", pin_drive, model_bus());
    endtask

    initial begin
        for (int i = 0; i < 4; i++) model[i] = 4'hF;
        test_reset();
        test_write();
        test_pattern();
        test_conflict();
        test_reads();
        test_back_to_back();
        test_same_cycle_write();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #200000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule